// File: doc/BRIEF.md
# Event-Selectable ADC Trigger Unit

This block starts an analog-to-digital conversion. It watches a bus of asynchronous event lines. A stored source code picks one of those lines, and a stored polarity bit decides whether the rising or the falling edge of that line counts as a trigger. Software can also start a conversion by writing a manual start pulse. The two trigger paths merge into one start strobe for the converter. That strobe is one clock wide and is only issued while the interface command is set to enable.

Each event line passes through a two-flop synchronizer before the edge detector sees it. Source codes outside the enumerated set act like the all-ones "no event" code, but they still read back exactly as written. The command field holds disable (0), enable (1) or flush (3). The unsupported code 2 reads back as written and acts like disable. After a flush command, software waits two cycles before it writes another command. When the source or the polarity changes, the edge detector skips one cycle, so the switch cannot produce a false trigger.

Top module: `adc_evt_trigger`

## Requirements
- R1: After reset, `adc_start` is 0, `src_rd` is 63 (no event), `fall_rd` is 0 and `cmd_rd` is 0 (disable).
- R2: A configuration write (`cfg_we`=1) is stored at that clock edge. From the next cycle, `src_rd`, `fall_rd` and `cmd_rd` return the written values exactly, including source codes outside the enumerated set and command code 2.
- R3: With polarity 0, interface enabled and a live source, a 0-to-1 change on the selected event line gives a strobe. The strobe is high in the third cycle after the cycle in which the line changed (two synchronizer flops plus the strobe register). A 1-to-0 change gives no strobe.
- R4: With polarity 1, a 1-to-0 change on the selected line gives a strobe with the same latency as R3, and a 0-to-1 change gives none.
- R5: Live source codes are 0 to 43, 46 to 56, and 61. Codes 44, 45, 57 to 60, 62 and 63 never produce an event strobe.
- R6: A manual start pulse (`man_we`=1 for one cycle) while `cmd_rd` is 1 drives `adc_start` high in the next cycle, whatever the source code is.
- R7: No strobe is issued while `cmd_rd` is 0 (disable), 2 (unsupported, same as disable) or 3 (flush). This holds for both the event path and the manual path.
- R8: Each qualifying edge or manual pulse gives a strobe exactly one cycle wide.
- R9: In the cycle right after the source code or the polarity changes, no event strobe is produced, even if the old and new selected lines differ in level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_async | input | 64 | Asynchronous event lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 6 | Source code to write |
| cfg_fall | input | 1 | Polarity to write (0 rising, 1 falling) |
| cfg_cmd | input | 2 | Interface command to write |
| man_we | input | 1 | Manual start write pulse |
| src_rd | output | 6 | Stored source code readback |
| fall_rd | output | 1 | Stored polarity readback |
| cmd_rd | output | 2 | Stored command readback |
| adc_start | output | 1 | One-cycle conversion start strobe |

## Verification
An event-line change driven between two edges shows up on `adc_start` three cycles later. A manual pulse shows up one cycle later, and configuration readback is due one cycle after the write. The bench drives all inputs on the falling clock edge and samples `adc_start` on later falling edges. The directed tests count falling edges from the stimulus and require the strobe on exactly the third one (event) or the first one (manual), with no other strobe in the window. The random phase runs a cycle-level reference model, built from the requirements, that advances on every rising edge, and compares its expected strobe with the design output on every falling edge.

// File: rtl/atu_pkg.sv
// Shared types and helpers for the ADC trigger unit.
// Assumes command codes fit in two bits and the source code indexes a live mask.
package atu_pkg;

    typedef enum logic [1:0] {
        CMD_OFF   = 2'd0,
        CMD_ON    = 2'd1,
        CMD_RSVD  = 2'd2,
        CMD_FLUSH = 2'd3
    } atu_cmd_e;

    // Live sources by default: 0..43, 46..56, 61; code 63 is "no event".
    localparam logic [63:0] ATU_LIVE_DEFAULT = 64'h21FF_CFFF_FFFF_FFFF;

    // True when the command allows strobes to leave the block.
    function automatic logic cmd_allows(input logic [1:0] c);
        return c == CMD_ON;
    endfunction

endpackage

// File: rtl/atu_evt_sync.sv
// Multi-stage synchronizer for a bus of asynchronous event lines.
// Assumes each line is a level that stays stable for at least two clocks.
module atu_evt_sync #(
    parameter int LINES  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);
    logic [LINES-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw lines into the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= raw_i;
                end
            end else begin : g_next
                // Pass the previous stage along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/atu_src_pick.sv
// Selects one synchronized event line by source code and reports if the code is live.
// Assumes LIVE_MASK marks the enumerated sources; other codes act like "no event".
module atu_src_pick #(
    parameter int              LINES     = 64,
    parameter int              SEL_W     = $clog2(LINES),
    parameter logic [LINES-1:0] LIVE_MASK = '0
) (
    input  logic [LINES-1:0] lines_i,
    input  logic [SEL_W-1:0] src_i,
    output logic             level_o,
    output logic             live_o
);
    // Mux the chosen line and look the code up in the live mask.
    always_comb begin
        level_o = lines_i[src_i];
        live_o  = LIVE_MASK[src_i];
    end
endmodule

// File: rtl/atu_edge_qual.sv
// Edge detector for the selected line, with polarity choice and a skip cycle
// after any source or polarity change.
// Assumes the line is already synchronized to clk.
module atu_edge_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic live_i,
    input  logic fall_i,
    input  logic moved_i,
    output logic hit_o
);
    logic hist_q;
    logic skip_q;
    logic rise_w;
    logic fall_w;

    // Keep last cycle's level of whichever line is selected now.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= level_i;
    end

    // Mark the cycle right after a selection change so its edge is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) skip_q <= 1'b0;
        else        skip_q <= moved_i;
    end

    // Form the qualified edge for the chosen polarity.
    always_comb begin
        rise_w = level_i & ~hist_q;
        fall_w = ~level_i & hist_q;
        hit_o  = live_i & ~skip_q & (fall_i ? fall_w : rise_w);
    end
endmodule

// File: rtl/adc_evt_trigger.sv
// Event-selectable ADC trigger: stores configuration, synchronizes events,
// picks a line, detects its edge, merges a manual start and issues a
// one-cycle start strobe while the interface is enabled.
// Assumes software waits two cycles after a flush before the next command.
module adc_evt_trigger #(
    parameter int               LINES     = 64,
    parameter int               STAGES    = 2,
    parameter logic [LINES-1:0] LIVE_MASK = atu_pkg::ATU_LIVE_DEFAULT,
    localparam int              SEL_W     = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] evt_async,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_src,
    input  logic             cfg_fall,
    input  logic [1:0]       cfg_cmd,
    input  logic             man_we,
    output logic [SEL_W-1:0] src_rd,
    output logic             fall_rd,
    output logic [1:0]       cmd_rd,
    output logic             adc_start
);
    import atu_pkg::*;

    localparam logic [SEL_W-1:0] SRC_NONE = {SEL_W{1'b1}};

    logic [SEL_W-1:0] src_q;
    logic             fall_q;
    logic [1:0]       cmd_q;
    logic [LINES-1:0] sync_w;
    logic             level_w;
    logic             live_w;
    logic             moved_w;
    logic             hit_w;
    logic             start_q;

    // Hold the configuration exactly as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_NONE;
            fall_q <= 1'b0;
            cmd_q  <= CMD_OFF;
        end else if (cfg_we) begin
            src_q  <= cfg_src;
            fall_q <= cfg_fall;
            cmd_q  <= cfg_cmd;
        end
    end

    // Flag a write that changes the line or the polarity.
    always_comb begin
        moved_w = cfg_we && ((cfg_src != src_q) || (cfg_fall != fall_q));
    end

    atu_evt_sync #(
        .LINES (LINES),
        .STAGES(STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (evt_async),
        .sync_o(sync_w)
    );

    atu_src_pick #(
        .LINES    (LINES),
        .SEL_W    (SEL_W),
        .LIVE_MASK(LIVE_MASK)
    ) u_pick (
        .lines_i(sync_w),
        .src_i  (src_q),
        .level_o(level_w),
        .live_o (live_w)
    );

    atu_edge_qual u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(level_w),
        .live_i (live_w),
        .fall_i (fall_q),
        .moved_i(moved_w),
        .hit_o  (hit_w)
    );

    // Register the merged, enable-qualified start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= cmd_allows(cmd_q) & (hit_w | man_we);
    end

    assign src_rd    = src_q;
    assign fall_rd   = fall_q;
    assign cmd_rd    = cmd_q;
    assign adc_start = start_q;
endmodule

// File: rtl/atu_checks.sv
// Property checker for the ADC trigger unit, bound to the top module.
// Assumes synchronous active-low reset on the same clock.
module atu_checks #(
    parameter int               LINES     = 64,
    parameter logic [LINES-1:0] LIVE_MASK = '0,
    localparam int              SEL_W     = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [SEL_W-1:0] cfg_src,
    input logic             cfg_fall,
    input logic [1:0]       cfg_cmd,
    input logic             man_we,
    input logic [SEL_W-1:0] src_rd,
    input logic             fall_rd,
    input logic [1:0]       cmd_rd,
    input logic             adc_start
);
    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (src_rd == $past(cfg_src)) && (fall_rd == $past(cfg_fall)) && (cmd_rd == $past(cfg_cmd))); // R2

    AST_DEAD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> ($past(man_we) || LIVE_MASK[$past(src_rd)])); // R5

    AST_MANUAL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (man_we && cmd_rd == 2'd1) |=> adc_start); // R6

    AST_GATED_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> ($past(cmd_rd) == 2'd1)); // R7

    AST_EVENT_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && $past(adc_start) && !$past(man_we, 2)) |-> $past(man_we)); // R8

    AST_NO_SWITCH_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && !$past(man_we)) |-> (($past(src_rd) == $past(src_rd, 2)) && ($past(fall_rd) == $past(fall_rd, 2)))); // R9
endmodule

bind adc_evt_trigger atu_checks #(
    .LINES    (LINES),
    .LIVE_MASK(LIVE_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_src  (cfg_src),
    .cfg_fall (cfg_fall),
    .cfg_cmd  (cfg_cmd),
    .man_we   (man_we),
    .src_rd   (src_rd),
    .fall_rd  (fall_rd),
    .cmd_rd   (cmd_rd),
    .adc_start(adc_start)
);

// File: tb/adc_evt_trigger_test.sv
module adc_evt_trigger_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt_async = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_src = 6'd63;
    logic        cfg_fall = 1'b0;
    logic [1:0]  cfg_cmd = 2'd0;
    logic        man_we = 1'b0;
    logic [5:0]  src_rd;
    logic        fall_rd;
    logic [1:0]  cmd_rd;
    logic        adc_start;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    adc_evt_trigger uut (
        .clk(clk), .rst_n(rst_n), .evt_async(evt_async),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_fall(cfg_fall), .cfg_cmd(cfg_cmd),
        .man_we(man_we), .src_rd(src_rd), .fall_rd(fall_rd), .cmd_rd(cmd_rd),
        .adc_start(adc_start)
    );

    // Enumerated source set from the requirements (R5).
    function automatic bit live_code(input logic [5:0] c);
        return (c <= 6'd43) || (c >= 6'd46 && c <= 6'd56) || (c == 6'd61);
    endfunction

    // Reference model from R3..R9, advanced on every rising edge.
    logic [63:0] m_s1 = '0, m_s2 = '0;
    logic [5:0]  m_src = 6'd63;
    logic        m_fall = 1'b0;
    logic [1:0]  m_cmd = 2'd0;
    logic        m_skip = 1'b0, m_prev = 1'b0, m_exp = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_src <= 6'd63; m_fall <= 1'b0; m_cmd <= 2'd0;
            m_skip <= 1'b0; m_prev <= 1'b0; m_exp <= 1'b0;
        end else begin
            m_s1 <= evt_async;
            m_s2 <= m_s1;
            m_prev <= m_s2[m_src];
            m_skip <= cfg_we && (cfg_src != m_src || cfg_fall != m_fall);
            m_exp <= (m_cmd == 2'd1) && (man_we || (live_code(m_src) && !m_skip &&
                     (m_fall ? (m_prev && !m_s2[m_src]) : (!m_prev && m_s2[m_src]))));
            if (cfg_we) begin
                m_src <= cfg_src; m_fall <= cfg_fall; m_cmd <= cfg_cmd;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [5:0] s, input logic f, input logic [1:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_src = s; cfg_fall = f; cfg_cmd = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count strobes over n falling edges and note where the first one was seen.
    task automatic watch(input int n, output int cnt, output int first);
        cnt = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (adc_start) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic set_line(input int idx, input logic v);
        @(negedge clk);
        evt_async[idx] = v;
    endtask

    task automatic manual_try(output logic seen, output int extra);
        int f;
        @(negedge clk);
        man_we = 1'b1;
        @(negedge clk);
        seen = adc_start;
        man_we = 1'b0;
        watch(4, extra, f);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int cnt, first, extra, flush_wait;
        logic seen;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(adc_start == 1'b0, "R1 start", adc_start, 0);
        chk(src_rd == 6'd63, "R1 src", src_rd, 63);
        chk(fall_rd == 1'b0, "R1 fall", fall_rd, 0);
        chk(cmd_rd == 2'd0, "R1 cmd", cmd_rd, 0);

        // R3 rising edge, latency 3, single cycle (R8)
        wr_cfg(6'd5, 1'b0, 2'd1);
        idle(4);
        set_line(5, 1'b1);
        watch(6, cnt, first);
        chk(first == 3, "R3 latency", first, 3);
        chk(cnt == 1, "R8 rise width", cnt, 1);
        set_line(5, 1'b0);
        watch(6, cnt, first);
        chk(cnt == 0, "R3 falling ignored", cnt, 0);

        // R4 falling polarity
        wr_cfg(6'd5, 1'b1, 2'd1);
        idle(4);
        set_line(5, 1'b1);
        watch(6, cnt, first);
        chk(cnt == 0, "R4 rising ignored", cnt, 0);
        set_line(5, 1'b0);
        watch(6, cnt, first);
        chk(first == 3, "R4 latency", first, 3);
        chk(cnt == 1, "R8 fall width", cnt, 1);

        // R2 readback of non-enumerated codes
        wr_cfg(6'd44, 1'b1, 2'd2);
        chk(src_rd == 6'd44, "R2 src", src_rd, 44);
        chk(cmd_rd == 2'd2, "R2 cmd", cmd_rd, 2);
        chk(fall_rd == 1'b1, "R2 fall", fall_rd, 1);

        // R5 dead codes never trigger, even when enabled
        foreach (seen_codes[k]) begin
            wr_cfg(seen_codes[k], 1'b0, 2'd1);
            idle(3);
            set_line(seen_codes[k], 1'b1);
            watch(5, cnt, first);
            set_line(seen_codes[k], 1'b0);
            idle(3);
            chk(cnt == 0, $sformatf("R5 code %0d", seen_codes[k]), cnt, 0);
        end

        // R6 manual start
        manual_try(seen, extra);
        chk(seen == 1'b1, "R6 manual strobe", seen, 1);
        chk(extra == 0, "R8 manual width", extra, 0);

        // R7 blocked in disable, unsupported and flush
        for (int c = 0; c < 4; c++) begin
            if (c == 1) continue;
            wr_cfg(6'd9, 1'b0, c[1:0]);
            idle(3);
            manual_try(seen, extra);
            chk(seen == 1'b0 && extra == 0, $sformatf("R7 manual cmd %0d", c), seen, 0);
            set_line(9, 1'b1);
            watch(5, cnt, first);
            set_line(9, 1'b0);
            idle(3);
            chk(cnt == 0, $sformatf("R7 event cmd %0d", c), cnt, 0);
        end

        // R9 switching to a line at a different level makes no strobe
        wr_cfg(6'd8, 1'b0, 2'd1);
        set_line(7, 1'b1);
        idle(5);
        wr_cfg(6'd7, 1'b0, 2'd1);
        watch(6, cnt, first);
        chk(cnt == 0, "R9 source switch", cnt, 0);
        set_line(7, 1'b0);
        idle(4);
        wr_cfg(6'd7, 1'b1, 2'd1);
        watch(6, cnt, first);
        chk(cnt == 0, "R9 polarity switch", cnt, 0);

        // Random phase against the model (R3 R4 R5 R6 R7 R9)
        flush_wait = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            chk(adc_start == m_exp, "R3 R4 R7 random strobe", adc_start, m_exp);
            cfg_we = 1'b0;
            man_we = ($urandom % 16) == 0;
            if ($urandom % 4 == 0) evt_async[m_src] = ~evt_async[m_src];
            if ($urandom % 4 == 0) evt_async[$urandom % 64] = $urandom % 2;
            if (flush_wait > 0) flush_wait--;
            else if ($urandom % 24 == 0) begin
                cfg_we = 1'b1;
                cfg_src = ($urandom % 3 == 0) ? 6'($urandom % 64) : 6'($urandom % 12);
                cfg_fall = $urandom % 2;
                cfg_cmd = ($urandom % 3 != 0) ? 2'd1 : 2'($urandom % 4);
                if (cfg_cmd == 2'd3) flush_wait = 3;
            end
        end
        @(negedge clk);
        cfg_we = 1'b0; man_we = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    logic [5:0] seen_codes [8] = '{6'd44, 6'd45, 6'd57, 6'd58, 6'd59, 6'd60, 6'd62, 6'd63};
endmodule